// File: doc/BRIEF.md
# Power-Management Register Target on I2C

This block is a bus target that sits on a two-wire I2C bus and gives a host control over the board's power functions. A host first writes one byte that picks an entry in an 8-bit register space. Some entries are commands: writing the selecting byte is enough to act, and there is no data phase. The other entries are ordinary byte registers: after the selecting byte, the host either writes one data byte or issues a repeated START and reads one byte back.

Commands switch the optical drive supply, request an eject, strobe reset lines toward three radio subsystems, and set the mode of three indicator LEDs. Byte registers hold a USB port power mask, a six-bit notification LED field, a fixed revision code, latched event flags and a bank of scratch bytes. The bus is sampled by the system clock. The target never stretches the clock, so bytes move between the bus engine and the register file as single-cycle posts with no back-pressure. The port pins are plain levels and pulses.

Top module: `pwr_i2c_target`

## Requirements
- R1: The target acknowledges only the 7-bit address 0x50. Any other address is NACKed (SDA left released in the acknowledge slot), and the transaction that follows changes no output.
- R2: In a write transaction the first byte after the address sets the selected index. The second byte is written to the selected register. Every later byte is acknowledged and discarded.
- R3: The selected index is kept across a repeated START. A read then returns the byte at that index, MSB first, and returns it again for each further byte that the host acknowledges.
- R4: A read at any command index (0x00, 0x01, 0x02, 0x10, 0x12, 0x13, 0x14, 0x15, 0x16, 0x1E, 0x1F, 0x20, 0x21, 0x22) returns 0xFF.
- R5: Selecting 0x00 sets `drive_pwr_o` to 1 and selecting 0x01 clears it. Selecting 0x02 raises `eject_o` for exactly one clock.
- R6: The LED mode outputs use the code 0 = off, 1 = on, 2 = pulse, and never take code 3. For the main LED, 0x10 selects on, 0x12 off and 0x13 pulse. For the auxiliary LED, 0x14 selects off, 0x15 on and 0x16 pulse. For the standby LED, 0x1E selects on and 0x1F pulse.
- R7: Selecting 0x20, 0x21 or 0x22 raises `bt_rst_o`, `wifi_rst_o` or `wifi2_rst_o`, in that order, for exactly one clock. Only the line that was selected is raised.
- R8: Index 0x40 reads 0xC5. Data written to it is ignored.
- R9: Index 0x41 reads the event flags, one bit per line: `evt_i[6]` on bit 6 (power button), `evt_i[5]` on bit 5 (eject button), `evt_i[4]` on bit 4 (disc insert), `evt_i[3]` on bit 3 (timer), `evt_i[2]` on bit 2 (radio interrupt), `evt_i[1]` on bit 1 (wake 0) and `evt_i[0]` on bit 0 (wake 1). Bit 7 reads 0. A flag is set by a rising edge on its line, holds until it has been read, and clears once that byte has been sent. A line that stays high does not set its flag again.
- R10: Index 0x43 holds the USB mask on bits 1:0 (bit 0 front, bit 1 rear), driven on `usb_pwr_o`. Index 0x44 holds the notification LED field on bits 5:0 (bit 5 blue on, bit 4 blue pulse, bit 3 red on, bit 2 red pulse, bit 1 yellow on, bit 0 yellow pulse), driven on `notif_led_o`. The unused upper bits read 0.
- R11: Indices 0x80 to 0xFF are read/write scratch bytes that reset to 0x00.
- R12: Any other index reads 0x00 and ignores written data.
- R13: After reset, SDA is released, every level and pulse output is 0 and every LED mode is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain driver enable) |
| evt_i | input | 7 | Event lines; rising edges set the event flags |
| drive_pwr_o | output | 1 | Optical drive supply enable |
| eject_o | output | 1 | One-clock eject request |
| bt_rst_o | output | 1 | One-clock Bluetooth reset |
| wifi_rst_o | output | 1 | One-clock primary Wi-Fi reset |
| wifi2_rst_o | output | 1 | One-clock secondary Wi-Fi reset |
| led_pwr_o | output | 2 | Main LED mode |
| led_aux_o | output | 2 | Auxiliary LED mode |
| led_stby_o | output | 2 | Standby LED mode |
| usb_pwr_o | output | 2 | USB port power mask |
| notif_led_o | output | 6 | Notification LED enable and pulse bits |

## Verification
The bench aims at these corner cases:

- **Wrong device address.** A design that decoded the address loosely would pull SDA in the acknowledge slot and then take the write that follows.
- **Extra data bytes.** Extra bytes in one write are sent. A target that auto-incremented or kept writing would change the mask a second time.
- **Reads at command indices and the revision code.** Each is read after a write was aimed at it, so a design that treated these entries as storage would return the written data.
- **Event flags.** A line that stays high must not set its flag again. The flags must clear only after they have been read. Each line is pulsed on its own, so a swapped bit order shows up as a wrong read value.

// File: rtl/pm_pkg.sv
package pm_pkg;

  typedef enum logic [1:0] {
    LED_OFF   = 2'd0,
    LED_ON    = 2'd1,
    LED_PULSE = 2'd2
  } led_mode_e;

  typedef enum logic [1:0] {
    BK_INDEX = 2'd0,
    BK_DATA  = 2'd1,
    BK_EXTRA = 2'd2
  } byte_kind_e;

  localparam logic [7:0] IX_DRV_ON     = 8'h00;
  localparam logic [7:0] IX_DRV_OFF    = 8'h01;
  localparam logic [7:0] IX_EJECT      = 8'h02;
  localparam logic [7:0] IX_PWR_ON     = 8'h10;
  localparam logic [7:0] IX_PWR_OFF    = 8'h12;
  localparam logic [7:0] IX_PWR_PULSE  = 8'h13;
  localparam logic [7:0] IX_AUX_OFF    = 8'h14;
  localparam logic [7:0] IX_AUX_ON     = 8'h15;
  localparam logic [7:0] IX_AUX_PULSE  = 8'h16;
  localparam logic [7:0] IX_STBY_ON    = 8'h1E;
  localparam logic [7:0] IX_STBY_PULSE = 8'h1F;
  localparam logic [7:0] IX_BT_RST     = 8'h20;
  localparam logic [7:0] IX_WIFI_RST   = 8'h21;
  localparam logic [7:0] IX_WIFI2_RST  = 8'h22;
  localparam logic [7:0] IX_REVISION   = 8'h40;
  localparam logic [7:0] IX_EVENTS     = 8'h41;
  localparam logic [7:0] IX_USB        = 8'h43;
  localparam logic [7:0] IX_NOTIF      = 8'h44;

endpackage

// File: rtl/pm_sync.sv
module pm_sync #(
  parameter int             W       = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/pm_i2c_link.sv
module pm_i2c_link
  import pm_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h50
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  output logic       wr_valid_o,
  output logic [7:0] wr_byte_o,
  output byte_kind_e wr_kind_o,
  output logic       rd_load_o,
  input  logic [7:0] rd_data_i,
  output logic       rd_done_o
);
  typedef enum logic [2:0] {
    L_IDLE, L_ADDR, L_WBYTE, L_ACKOUT, L_RBYTE, L_ACKIN
  } lstate_e;

  lstate_e    st_q;
  logic       scl_q, sda_q;
  logic [3:0] bcnt_q;
  logic [7:0] sh_q;
  logic       rw_q, oe_q, mnack_q;
  logic       seen_idx_q, seen_dat_q;

  logic start_det, stop_det, scl_rise, scl_fall;

  assign start_det = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;
  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= L_IDLE;
      bcnt_q     <= '0;
      sh_q       <= '0;
      rw_q       <= 1'b0;
      oe_q       <= 1'b0;
      mnack_q    <= 1'b1;
      seen_idx_q <= 1'b0;
      seen_dat_q <= 1'b0;
      wr_valid_o <= 1'b0;
      wr_byte_o  <= '0;
      wr_kind_o  <= BK_INDEX;
      rd_load_o  <= 1'b0;
      rd_done_o  <= 1'b0;
    end else begin
      wr_valid_o <= 1'b0;
      rd_load_o  <= 1'b0;
      rd_done_o  <= 1'b0;
      if (start_det) begin
        st_q       <= L_ADDR;
        bcnt_q     <= '0;
        oe_q       <= 1'b0;
        seen_idx_q <= 1'b0;
        seen_dat_q <= 1'b0;
      end else if (stop_det) begin
        st_q <= L_IDLE;
        oe_q <= 1'b0;
      end else begin
        unique case (st_q)
          L_ADDR, L_WBYTE: begin
            if (scl_rise && bcnt_q < 4'd8) begin
              sh_q   <= {sh_q[6:0], sda_i};
              bcnt_q <= bcnt_q + 4'd1;
            end else if (scl_fall && bcnt_q == 4'd8) begin
              if (st_q == L_ADDR) begin
                if (sh_q[7:1] == DEV_ADDR) begin
                  oe_q <= 1'b1;
                  rw_q <= sh_q[0];
                  st_q <= L_ACKOUT;
                end else begin
                  st_q <= L_IDLE;
                end
              end else begin
                wr_valid_o <= 1'b1;
                wr_byte_o  <= sh_q;
                if (!seen_idx_q) begin
                  wr_kind_o  <= BK_INDEX;
                  seen_idx_q <= 1'b1;
                end else if (!seen_dat_q) begin
                  wr_kind_o  <= BK_DATA;
                  seen_dat_q <= 1'b1;
                end else begin
                  wr_kind_o <= BK_EXTRA;
                end
                oe_q <= 1'b1;
                st_q <= L_ACKOUT;
              end
            end
          end
          L_ACKOUT: begin
            if (scl_fall) begin
              if (rw_q) begin
                sh_q      <= rd_data_i;
                oe_q      <= ~rd_data_i[7];
                bcnt_q    <= 4'd1;
                rd_load_o <= 1'b1;
                st_q      <= L_RBYTE;
              end else begin
                oe_q   <= 1'b0;
                bcnt_q <= '0;
                st_q   <= L_WBYTE;
              end
            end
          end
          L_RBYTE: begin
            if (scl_fall) begin
              if (bcnt_q < 4'd8) begin
                oe_q   <= ~sh_q[6];
                sh_q   <= {sh_q[6:0], 1'b0};
                bcnt_q <= bcnt_q + 4'd1;
              end else begin
                oe_q      <= 1'b0;
                rd_done_o <= 1'b1;
                st_q      <= L_ACKIN;
              end
            end
          end
          L_ACKIN: begin
            if (scl_rise) begin
              mnack_q <= sda_i;
            end else if (scl_fall) begin
              if (!mnack_q) begin
                sh_q      <= rd_data_i;
                oe_q      <= ~rd_data_i[7];
                bcnt_q    <= 4'd1;
                rd_load_o <= 1'b1;
                st_q      <= L_RBYTE;
              end else begin
                st_q <= L_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o = oe_q;
endmodule

// File: rtl/pm_regs.sv
module pm_regs
  import pm_pkg::*;
#(
  parameter logic [7:0] REVISION      = 8'hC5,
  parameter int         N_EVT         = 7,
  parameter int         SCRATCH_BASE  = 128,
  parameter int         SCRATCH_DEPTH = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_valid_i,
  input  logic [7:0]       wr_byte_i,
  input  byte_kind_e       wr_kind_i,
  input  logic             rd_load_i,
  input  logic             rd_done_i,
  output logic [7:0]       rd_data_o,
  input  logic [N_EVT-1:0] evt_i,
  output logic             drive_pwr_o,
  output logic             eject_o,
  output logic             bt_rst_o,
  output logic             wifi_rst_o,
  output logic             wifi2_rst_o,
  output led_mode_e        led_pwr_o,
  output led_mode_e        led_aux_o,
  output led_mode_e        led_stby_o,
  output logic [1:0]       usb_pwr_o,
  output logic [5:0]       notif_o
);
  // Scratch bank must be aligned to its own size.
  localparam int SAW         = $clog2(SCRATCH_DEPTH);
  localparam int SCRATCH_END = SCRATCH_BASE + SCRATCH_DEPTH;

  logic [7:0]       idx_q;
  logic [7:0]       scratch_q [SCRATCH_DEPTH];
  logic [N_EVT-1:0] evt_q, evt_rise, flags_q, snap_q;
  logic             in_scratch;

  function automatic logic is_cmd(input logic [7:0] x);
    case (x)
      IX_DRV_ON, IX_DRV_OFF, IX_EJECT,
      IX_PWR_ON, IX_PWR_OFF, IX_PWR_PULSE,
      IX_AUX_OFF, IX_AUX_ON, IX_AUX_PULSE,
      IX_STBY_ON, IX_STBY_PULSE,
      IX_BT_RST, IX_WIFI_RST, IX_WIFI2_RST: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  assign in_scratch = (int'(idx_q) >= SCRATCH_BASE) && (int'(idx_q) < SCRATCH_END);

  // Rising-edge detect per event line
  for (genvar g = 0; g < N_EVT; g++) begin : g_evt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) evt_q[g] <= 1'b0;
      else         evt_q[g] <= evt_i[g];
    end
    assign evt_rise[g] = evt_i[g] & ~evt_q[g];
  end

  // Flags: set on edge, cleared for the bits sent once the byte is out
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      snap_q  <= '0;
    end else begin
      if (rd_load_i) snap_q <= (idx_q == IX_EVENTS) ? flags_q : '0;
      flags_q <= (flags_q & ~(rd_done_i ? snap_q : '0)) | evt_rise;
    end
  end

  // Index, commands and control registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q       <= '0;
      drive_pwr_o <= 1'b0;
      eject_o     <= 1'b0;
      bt_rst_o    <= 1'b0;
      wifi_rst_o  <= 1'b0;
      wifi2_rst_o <= 1'b0;
      led_pwr_o   <= LED_OFF;
      led_aux_o   <= LED_OFF;
      led_stby_o  <= LED_OFF;
      usb_pwr_o   <= '0;
      notif_o     <= '0;
    end else begin
      eject_o     <= 1'b0;
      bt_rst_o    <= 1'b0;
      wifi_rst_o  <= 1'b0;
      wifi2_rst_o <= 1'b0;
      if (wr_valid_i && wr_kind_i == BK_INDEX) begin
        idx_q <= wr_byte_i;
        case (wr_byte_i)
          IX_DRV_ON:     drive_pwr_o <= 1'b1;
          IX_DRV_OFF:    drive_pwr_o <= 1'b0;
          IX_EJECT:      eject_o     <= 1'b1;
          IX_PWR_ON:     led_pwr_o   <= LED_ON;
          IX_PWR_OFF:    led_pwr_o   <= LED_OFF;
          IX_PWR_PULSE:  led_pwr_o   <= LED_PULSE;
          IX_AUX_OFF:    led_aux_o   <= LED_OFF;
          IX_AUX_ON:     led_aux_o   <= LED_ON;
          IX_AUX_PULSE:  led_aux_o   <= LED_PULSE;
          IX_STBY_ON:    led_stby_o  <= LED_ON;
          IX_STBY_PULSE: led_stby_o  <= LED_PULSE;
          IX_BT_RST:     bt_rst_o    <= 1'b1;
          IX_WIFI_RST:   wifi_rst_o  <= 1'b1;
          IX_WIFI2_RST:  wifi2_rst_o <= 1'b1;
          default: ;
        endcase
      end else if (wr_valid_i && wr_kind_i == BK_DATA) begin
        case (idx_q)
          IX_USB:   usb_pwr_o <= wr_byte_i[1:0];
          IX_NOTIF: notif_o   <= wr_byte_i[5:0];
          default: ;
        endcase
      end
    end
  end

  // Scratch bank
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SCRATCH_DEPTH; i++) scratch_q[i] <= '0;
    end else if (wr_valid_i && wr_kind_i == BK_DATA && in_scratch) begin
      scratch_q[idx_q[SAW-1:0]] <= wr_byte_i;
    end
  end

  // Read mux
  always_comb begin
    rd_data_o = 8'h00;
    if (is_cmd(idx_q)) begin
      rd_data_o = 8'hFF;
    end else if (in_scratch) begin
      rd_data_o = scratch_q[idx_q[SAW-1:0]];
    end else begin
      case (idx_q)
        IX_REVISION: rd_data_o = REVISION;
        IX_EVENTS:   rd_data_o = 8'(flags_q);
        IX_USB:      rd_data_o = {6'b0, usb_pwr_o};
        IX_NOTIF:    rd_data_o = {2'b0, notif_o};
        default:     rd_data_o = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/pwr_i2c_target.sv
module pwr_i2c_target
  import pm_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR      = 7'h50,
  parameter logic [7:0] REVISION      = 8'hC5,
  parameter int         N_EVT         = 7,
  parameter int         SCRATCH_BASE  = 128,
  parameter int         SCRATCH_DEPTH = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  input  logic [N_EVT-1:0] evt_i,
  output logic             drive_pwr_o,
  output logic             eject_o,
  output logic             bt_rst_o,
  output logic             wifi_rst_o,
  output logic             wifi2_rst_o,
  output logic [1:0]       led_pwr_o,
  output logic [1:0]       led_aux_o,
  output logic [1:0]       led_stby_o,
  output logic [1:0]       usb_pwr_o,
  output logic [5:0]       notif_led_o
);
  logic             scl_s, sda_s;
  logic [N_EVT-1:0] evt_s;
  logic             wr_valid, rd_load, rd_done;
  logic [7:0]       wr_byte, rd_data;
  byte_kind_e       wr_kind;
  led_mode_e        m_pwr, m_aux, m_stby;

  pm_sync #(.W(2), .RST_VAL(2'b11)) i_bus_sync (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .d_i({scl_i, sda_i}), .q_o({scl_s, sda_s})
  );

  pm_sync #(.W(N_EVT), .RST_VAL('0)) i_evt_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(evt_i), .q_o(evt_s)
  );

  pm_i2c_link #(.DEV_ADDR(DEV_ADDR)) i_link (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .scl_i(scl_s), .sda_i(sda_s), .sda_oe_o(sda_oe_o),
    .wr_valid_o(wr_valid), .wr_byte_o(wr_byte), .wr_kind_o(wr_kind),
    .rd_load_o(rd_load), .rd_data_i(rd_data), .rd_done_o(rd_done)
  );

  pm_regs #(
    .REVISION(REVISION), .N_EVT(N_EVT),
    .SCRATCH_BASE(SCRATCH_BASE), .SCRATCH_DEPTH(SCRATCH_DEPTH)
  ) i_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_valid_i(wr_valid), .wr_byte_i(wr_byte), .wr_kind_i(wr_kind),
    .rd_load_i(rd_load), .rd_done_i(rd_done), .rd_data_o(rd_data),
    .evt_i(evt_s),
    .drive_pwr_o(drive_pwr_o), .eject_o(eject_o),
    .bt_rst_o(bt_rst_o), .wifi_rst_o(wifi_rst_o), .wifi2_rst_o(wifi2_rst_o),
    .led_pwr_o(m_pwr), .led_aux_o(m_aux), .led_stby_o(m_stby),
    .usb_pwr_o(usb_pwr_o), .notif_o(notif_led_o)
  );

  assign led_pwr_o  = m_pwr;
  assign led_aux_o  = m_aux;
  assign led_stby_o = m_stby;
endmodule

// File: rtl/pm_target_chk.sv
module pm_target_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_valid,
  input logic       eject_o,
  input logic       bt_rst_o,
  input logic       wifi_rst_o,
  input logic       wifi2_rst_o,
  input logic [1:0] led_pwr_o,
  input logic [1:0] led_aux_o,
  input logic [1:0] led_stby_o,
  input logic [1:0] usb_pwr_o,
  input logic [5:0] notif_led_o
);
  AST_EJECT_ONE_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eject_o |=> !eject_o); // R5

  AST_RADIO_RST_ONE_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bt_rst_o || wifi_rst_o || wifi2_rst_o) |=> !(bt_rst_o || wifi_rst_o || wifi2_rst_o)); // R7

  AST_PULSES_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({eject_o, bt_rst_o, wifi_rst_o, wifi2_rst_o})); // R7

  AST_LED_MODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (led_pwr_o != 2'd3) && (led_aux_o != 2'd3) && (led_stby_o != 2'd3)); // R6

  AST_CTRL_HOLD_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_valid |=> ($stable(usb_pwr_o) && $stable(notif_led_o))); // R10
endmodule

bind pwr_i2c_target pm_target_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_valid(wr_valid),
  .eject_o(eject_o), .bt_rst_o(bt_rst_o), .wifi_rst_o(wifi_rst_o),
  .wifi2_rst_o(wifi2_rst_o), .led_pwr_o(led_pwr_o), .led_aux_o(led_aux_o),
  .led_stby_o(led_stby_o), .usb_pwr_o(usb_pwr_o), .notif_led_o(notif_led_o)
);

// File: tb/test_pwr_i2c_target.sv
`timescale 1ns/1ps
module test_pwr_i2c_target;
  localparam int H = 20; // clocks per quarter bit

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1;
  logic       m_sda_low = 1'b0;
  logic [6:0] evt = '0;
  logic       sda_oe, drv, ej, bt, wf, wf2;
  logic [1:0] lp, la, ls, usb;
  logic [5:0] notif;
  wire        sda_line = !(m_sda_low || sda_oe);

  pwr_i2c_target i_pwr_i2c_target (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .evt_i(evt), .drive_pwr_o(drv), .eject_o(ej),
    .bt_rst_o(bt), .wifi_rst_o(wf), .wifi2_rst_o(wf2),
    .led_pwr_o(lp), .led_aux_o(la), .led_stby_o(ls),
    .usb_pwr_o(usb), .notif_led_o(notif)
  );

  int n_chk = 0, n_err = 0;
  bit done = 1'b0, sync = 1'b0;

  // reference model state
  logic       e_drv = 0;
  logic [1:0] e_lp = 0, e_la = 0, e_ls = 0, e_usb = 0;
  logic [5:0] e_notif = 0;
  int e_ej = 0, e_bt = 0, e_wf = 0, e_wf2 = 0;
  int c_ej = 0, c_bt = 0, c_wf = 0, c_wf2 = 0;

  always @(negedge clk) if (rst_n) begin
    if (ej) c_ej++;
    if (bt) c_bt++;
    if (wf) c_wf++;
    if (wf2) c_wf2++;
  end

  // every-clock comparison against the model while the bus is idle
  always @(negedge clk) if (rst_n && sync && !done) begin
    n_chk++;
    if ({sda_oe, drv, lp, la, ls, usb, notif} != {1'b0, e_drv, e_lp, e_la, e_ls, e_usb, e_notif}) begin
      n_err++;
      $display("FAIL R5 R6 R10 R13 levels act=%h exp=%h",
               {sda_oe, drv, lp, la, ls, usb, notif},
               {1'b0, e_drv, e_lp, e_la, e_ls, e_usb, e_notif});
    end
    n_chk++;
    if (c_ej != e_ej || c_bt != e_bt || c_wf != e_wf || c_wf2 != e_wf2) begin
      n_err++;
      $display("FAIL R5 R7 pulse counts act=%0d/%0d/%0d/%0d exp=%0d/%0d/%0d/%0d",
               c_ej, c_bt, c_wf, c_wf2, e_ej, e_bt, e_wf, e_wf2);
    end
  end

  task automatic hw(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic void apply_index(input logic [7:0] x);
    case (x)
      8'h00: e_drv = 1'b1;
      8'h01: e_drv = 1'b0;
      8'h02: e_ej++;
      8'h10: e_lp = 2'd1;
      8'h12: e_lp = 2'd0;
      8'h13: e_lp = 2'd2;
      8'h14: e_la = 2'd0;
      8'h15: e_la = 2'd1;
      8'h16: e_la = 2'd2;
      8'h1E: e_ls = 2'd1;
      8'h1F: e_ls = 2'd2;
      8'h20: e_bt++;
      8'h21: e_wf++;
      8'h22: e_wf2++;
      default: ;
    endcase
  endfunction

  function automatic void apply_data(input logic [7:0] x, input logic [7:0] d);
    if (x == 8'h43) e_usb = d[1:0];
    if (x == 8'h44) e_notif = d[5:0];
  endfunction

  task automatic bit_cycle(input logic b, output logic s);
    m_sda_low = !b;
    hw(H);
    m_scl = 1'b1;
    hw(H);
    s = sda_line;
    hw(H);
    m_scl = 1'b0;
    hw(H);
  endtask

  task automatic i2c_start();
    m_sda_low = 1'b0;
    hw(H);
    m_scl = 1'b1;
    hw(2*H);
    m_sda_low = 1'b1;
    hw(2*H);
    m_scl = 1'b0;
    hw(H);
  endtask

  task automatic i2c_stop();
    m_sda_low = 1'b1;
    hw(H);
    m_scl = 1'b1;
    hw(2*H);
    m_sda_low = 1'b0;
    hw(4*H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic nak);
    logic s;
    for (int i = 7; i >= 0; i--) bit_cycle(b[i], s);
    bit_cycle(1'b1, nak);
  endtask

  task automatic recv_byte(input logic master_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_cycle(1'b1, s);
      b[i] = s;
    end
    bit_cycle(!master_ack, s);
  endtask

  task automatic settle();
    hw(10);
    sync = 1'b1;
  endtask

  task automatic bus_write(input logic [6:0] dev, input logic [7:0] x, input int n,
                           input logic [7:0] d0, input logic [7:0] d1, output logic nak);
    logic k;
    sync = 1'b0;
    i2c_start();
    send_byte({dev, 1'b0}, nak);
    if (!nak) begin
      send_byte(x, k);
      if (n >= 1) begin send_byte(d0, k); check8("R2 data byte ack", {7'b0, k}, 8'h00); end
      if (n >= 2) begin send_byte(d1, k); check8("R2 extra byte ack", {7'b0, k}, 8'h00); end
    end else begin
      send_byte(x, k);
    end
    i2c_stop();
    if (dev == 7'h50) begin
      apply_index(x);
      if (n >= 1) apply_data(x, d0);
    end
    settle();
  endtask

  task automatic bus_read(input logic [7:0] x, input int n,
                          output logic [7:0] b0, output logic [7:0] b1);
    logic k;
    sync = 1'b0;
    b1 = 8'h00;
    i2c_start();
    send_byte(8'hA0, k);
    send_byte(x, k);
    i2c_start();
    send_byte(8'hA1, k);
    check8("R3 read address ack", {7'b0, k}, 8'h00);
    recv_byte(n > 1, b0);
    if (n > 1) recv_byte(1'b0, b1);
    i2c_stop();
    apply_index(x);
    settle();
  endtask

  task automatic rd1(input logic [7:0] x, input logic [7:0] exp, input string tag);
    logic [7:0] a, b;
    bus_read(x, 1, a, b);
    check8(tag, a, exp);
  endtask

  initial begin
    logic nak;
    logic [7:0] a, b;
    hw(10);
    rst_n = 1'b1;
    hw(5);
    // R13 reset state
    check8("R13 reset outputs", {sda_oe, drv, ej, bt, wf, wf2, lp}, 8'h00);
    check8("R13 reset outputs", {la, ls, usb, 2'b00}, 8'h00);
    sync = 1'b1;

    // R1 foreign address: NACK, no effect
    bus_write(7'h51, 8'h43, 1, 8'h03, 8'h00, nak);
    check8("R1 foreign address nack", {7'b0, nak}, 8'h01);
    bus_write(7'h50, 8'h43, 1, 8'h02, 8'h00, nak);
    check8("R1 own address ack", {7'b0, nak}, 8'h00);
    bus_write(7'h28, 8'h00, 0, 8'h00, 8'h00, nak);
    check8("R1 foreign address nack", {7'b0, nak}, 8'h01);

    // R10 masks
    bus_write(7'h50, 8'h43, 1, 8'hFF, 8'h00, nak);
    rd1(8'h43, 8'h03, "R10 usb mask readback");
    bus_write(7'h50, 8'h44, 1, 8'hFF, 8'h00, nak);
    rd1(8'h44, 8'h3F, "R10 notif readback");
    bus_write(7'h50, 8'h44, 1, 8'h15, 8'h00, nak);

    // R2 extra byte ignored
    bus_write(7'h50, 8'h43, 2, 8'h01, 8'h02, nak);
    rd1(8'h43, 8'h01, "R2 extra byte discarded");

    // R5 R6 R7 commands
    bus_write(7'h50, 8'h00, 0, 8'h00, 8'h00, nak);
    bus_write(7'h50, 8'h02, 0, 8'h00, 8'h00, nak);
    bus_write(7'h50, 8'h13, 0, 8'h00, 8'h00, nak);
    bus_write(7'h50, 8'h16, 0, 8'h00, 8'h00, nak);
    bus_write(7'h50, 8'h1E, 0, 8'h00, 8'h00, nak);
    bus_write(7'h50, 8'h20, 0, 8'h00, 8'h00, nak);
    bus_write(7'h50, 8'h21, 0, 8'h00, 8'h00, nak);
    bus_write(7'h50, 8'h22, 0, 8'h00, 8'h00, nak);
    check8("R6 main led pulse", {6'b0, lp}, 8'h02);
    check8("R5 drive on", {7'b0, drv}, 8'h01);
    bus_write(7'h50, 8'h01, 0, 8'h00, 8'h00, nak);
    bus_write(7'h50, 8'h10, 0, 8'h00, 8'h00, nak);
    bus_write(7'h50, 8'h15, 0, 8'h00, 8'h00, nak);
    bus_write(7'h50, 8'h1F, 0, 8'h00, 8'h00, nak);
    bus_write(7'h50, 8'h12, 0, 8'h00, 8'h00, nak);
    bus_write(7'h50, 8'h14, 0, 8'h00, 8'h00, nak);
    check8("R6 standby led pulse", {6'b0, ls}, 8'h02);
    check8("R7 one pulse each", 8'(c_bt + c_wf + c_wf2), 8'd3);

    // R4 command reads
    rd1(8'h13, 8'hFF, "R4 command index read");
    rd1(8'h21, 8'hFF, "R4 command index read");
    bus_write(7'h50, 8'h02, 1, 8'h5A, 8'h00, nak);
    rd1(8'h02, 8'hFF, "R4 command index after data");

    // R8 revision
    rd1(8'h40, 8'hC5, "R8 revision");
    bus_write(7'h50, 8'h40, 1, 8'h00, 8'h00, nak);
    rd1(8'h40, 8'hC5, "R8 revision write ignored");

    // R11 scratch
    rd1(8'h90, 8'h00, "R11 scratch reset value");
    bus_write(7'h50, 8'h80, 1, 8'hA5, 8'h00, nak);
    bus_write(7'h50, 8'hFF, 1, 8'h3C, 8'h00, nak);
    rd1(8'hFF, 8'h3C, "R11 scratch top");
    bus_read(8'h80, 2, a, b);
    check8("R11 R3 scratch base", a, 8'hA5);
    check8("R3 repeated byte", b, 8'hA5);

    // R12 undecoded
    bus_write(7'h50, 8'h30, 1, 8'h77, 8'h00, nak);
    rd1(8'h30, 8'h00, "R12 undecoded index");
    bus_write(7'h50, 8'h11, 1, 8'h77, 8'h00, nak);
    rd1(8'h11, 8'h00, "R12 undecoded index");

    // R9 event flags
    rd1(8'h41, 8'h00, "R9 flags idle");
    evt = 7'b1000001;
    hw(10);
    rd1(8'h41, 8'h41, "R9 flags set by edges");
    rd1(8'h41, 8'h00, "R9 flags cleared, level held");
    evt = '0;
    hw(10);
    for (int i = 0; i < 7; i++) begin
      evt[i] = 1'b1;
      hw(3);
      evt[i] = 1'b0;
      hw(10);
      rd1(8'h41, 8'(1 << i), "R9 flag bit position");
    end

    sync = 1'b0;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule